// File: doc/BRIEF.md
# Secure-Banked Interrupt Group Control

This block holds the global control state of an interrupt distributor and resolves, for every interrupt line, which of three interrupt groups it belongs to. The groups are group 0, secure group 1 and non-secure group 1. The control word is banked. A secure access, a non-secure access and any access made while security is disabled each see their own layout of that word, and each may write only its own fields.

The block also stores two per-interrupt fields. One is a group-modifier bit. The other is a 2-bit non-secure access level. Only secure software can reach these fields, and only while security is enabled. Downstream logic takes three results from the block: each interrupt's decoded group, whether that group is currently enabled, and each interrupt's access level. The per-interrupt group bits come in from the outside. Enable, pending and priority state live elsewhere.

Register accesses are single-cycle requests. Read data appears on `rd_data` on the clock edge after the request.

Top module: `irq_grp_ctrl`

## Requirements
- R1: After reset all three group enables are 0. The disable-security flag is 0 when `HAS_SECURITY` is 1 and 1 otherwise. All modifier and access-level bits are 0.
- R2: With security enabled, a secure read of the control word (word offset 0x000) returns the group 0 enable in bit 0, the non-secure group 1 enable in bit 1, the secure group 1 enable in bit 2, ones in bits 4 and 5, and the disable-security flag in bit 6. All other bits read 0.
- R3: With security enabled, a non-secure control read returns 1 in bit 4 and the non-secure group 1 enable in bit 1, with every other bit 0. A non-secure control write changes only the non-secure group 1 enable, which it takes from bit 1.
- R4: With security enabled, a secure control write loads the disable-security flag from bit 6, the group 0 enable from bit 0, the non-secure group 1 enable from bit 1 and the secure group 1 enable from bit 2. When bit 6 is written as 1, the secure group 1 enable is set to 0 instead.
- R5: With security disabled, a control read returns 1 in bit 6, 1 in bit 4, the non-secure group 1 enable in bit 1 and the group 0 enable in bit 0. A write changes only those two enables. Once set, the flag stays set until reset.
- R6: The decoded group on `irq_grp_sel[2i+1:2i]` uses the codes 00 for group 0, 01 for non-secure group 1 and 10 for secure group 1. With security disabled, a group bit of 1 gives 01 and a group bit of 0 gives 00. With security enabled, a group bit of 1 gives 01, and a group bit of 0 gives 10 if the modifier bit is 1 and 00 if it is 0.
- R7: The modifier bits sit at 0xD00, one bit per interrupt: interrupt i is at word i/32, bit i%32. The access levels sit at 0xE00, two bits per interrupt: interrupt i is at word i/16, bits 2(i%16)+1:2(i%16). These words read as 0 and ignore writes when security is disabled or when the access is non-secure.
- R8: `irq_grp_en[i]` equals the current enable bit of interrupt i's decoded group. It follows group bits and control changes in the same cycle.
- R9: Read data is returned on the edge after the read request. An offset that is not mapped reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Register access request |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_sec | input | 1 | 1 when the access is secure |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, registered |
| irq_grp_bit | input | NUM_IRQ | Per-interrupt group bit from the group registers |
| irq_grp_sel | output | 2*NUM_IRQ | Decoded group code per interrupt |
| irq_grp_en | output | NUM_IRQ | Enable bit of each interrupt's decoded group |
| irq_ns_lvl | output | 2*NUM_IRQ | Non-secure access level per interrupt |

## Verification
The bench drives random mixes of secure and non-secure reads and writes across the control word, both banked arrays and unmapped offsets, in two phases. In the first phase security stays enabled, so the secure, non-secure and modifier-dependent decode paths can be told apart. The second phase starts after a directed write that disables security, which shows that the flag is sticky, that secure group 1 is cleared, and that the arrays lock. Each operation presents fresh random group bits, so the decode and group-enable outputs are compared against a bench model for every mix of group bit, modifier bit and enable state.

// File: rtl/irq_grp_pkg.sv
`timescale 1ns/1ps
// Package: shared group codes, control bit positions and region offsets.
// Assumes a byte-addressed register space with 32-bit aligned words.
package irq_grp_pkg;

    typedef enum logic [1:0] {
        GRP_0    = 2'b00,
        GRP_1NS  = 2'b01,
        GRP_1S   = 2'b10
    } grp_e;

    // Control word bit positions
    localparam int CB_G0       = 0;
    localparam int CB_G1NS     = 1;
    localparam int CB_G1S      = 2;
    localparam int CB_ROUTE_S  = 4;
    localparam int CB_ROUTE_NS = 5;
    localparam int CB_DS       = 6;

    // Region base offsets
    localparam logic [11:0] MOD_BASE = 12'hD00;
    localparam logic [11:0] LVL_BASE = 12'hE00;

    // Decode an interrupt's effective group from security mode and its bits
    function automatic grp_e grp_decode(input logic ds, input logic gbit,
                                        input logic mbit);
        if (gbit)
            return GRP_1NS;
        else if (!ds && mbit)
            return GRP_1S;
        else
            return GRP_0;
    endfunction

endpackage

// File: rtl/grp_ctrl_reg.sv
`timescale 1ns/1ps
// Banked control word: holds the three group enables and the
// disable-security flag, and presents the secure, non-secure or
// security-disabled view of the word. Assumes wr_en is a qualified
// write hit on the control offset.
module grp_ctrl_reg
    import irq_grp_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter bit HAS_SECURITY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sec,
    input  logic [DATA_W-1:0] wdata,
    output logic              ds,
    output logic              en_g0,
    output logic              en_g1ns,
    output logic              en_g1s,
    output logic [DATA_W-1:0] rdata
);

    // State update according to the view of the writer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds      <= !HAS_SECURITY;
            en_g0   <= 1'b0;
            en_g1ns <= 1'b0;
            en_g1s  <= 1'b0;
        end else if (wr_en) begin
            if (ds) begin
                en_g0   <= wdata[CB_G0];
                en_g1ns <= wdata[CB_G1NS];
            end else if (sec) begin
                ds      <= wdata[CB_DS];
                en_g0   <= wdata[CB_G0];
                en_g1ns <= wdata[CB_G1NS];
                en_g1s  <= wdata[CB_DS] ? 1'b0 : wdata[CB_G1S];
            end else begin
                en_g1ns <= wdata[CB_G1NS];
            end
        end
    end

    // Read view selection
    always_comb begin
        rdata = '0;
        if (ds) begin
            rdata[CB_DS]      = 1'b1;
            rdata[CB_ROUTE_S] = 1'b1;
            rdata[CB_G1NS]    = en_g1ns;
            rdata[CB_G0]      = en_g0;
        end else if (sec) begin
            rdata[CB_ROUTE_NS] = 1'b1;
            rdata[CB_ROUTE_S]  = 1'b1;
            rdata[CB_G1S]      = en_g1s;
            rdata[CB_G1NS]     = en_g1ns;
            rdata[CB_G0]       = en_g0;
        end else begin
            rdata[CB_ROUTE_S] = 1'b1;
            rdata[CB_G1NS]    = en_g1ns;
        end
    end

endmodule

// File: rtl/grp_mod_bank.sv
`timescale 1ns/1ps
// Secure-only storage for per-interrupt modifier bits (1 bit each) and
// non-secure access levels (2 bits each). Assumes acc_ok is high only
// for secure accesses with security enabled; otherwise reads give 0
// and writes are dropped.
module grp_mod_bank
    import irq_grp_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 req_wr,
    input  logic                 acc_ok,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_IRQ-1:0]   mod_bits,
    output logic [2*NUM_IRQ-1:0] lvl_bits,
    output logic [DATA_W-1:0]    rdata
);

    localparam int BYTES_W   = DATA_W / 8;
    localparam int MOD_WORDS = (NUM_IRQ + DATA_W - 1) / DATA_W;
    localparam int LVL_PER_W = DATA_W / 2;
    localparam int LVL_WORDS = (NUM_IRQ + LVL_PER_W - 1) / LVL_PER_W;
    localparam int IDX_W     = ADDR_W - 2;

    logic [MOD_WORDS*DATA_W-1:0] mod_q;
    logic [LVL_WORDS*DATA_W-1:0] lvl_q;
    logic [ADDR_W-1:0]           mod_off, lvl_off;
    logic                        mod_hit, lvl_hit, wr_ok;
    logic [MOD_WORDS-1:0]        mod_sel;
    logic [LVL_WORDS-1:0]        lvl_sel;

    // Region offsets and hit detection
    assign mod_off = req_addr - ADDR_W'(MOD_BASE);
    assign lvl_off = req_addr - ADDR_W'(LVL_BASE);
    assign mod_hit = mod_off < ADDR_W'(MOD_WORDS * BYTES_W);
    assign lvl_hit = lvl_off < ADDR_W'(LVL_WORDS * BYTES_W);
    assign wr_ok   = req_vld && req_wr && acc_ok;

    for (genvar w = 0; w < MOD_WORDS; w++) begin : g_mod
        assign mod_sel[w] = mod_hit && (mod_off[ADDR_W-1:2] == IDX_W'(w));
        // Modifier word storage
        always_ff @(posedge clk) begin
            if (!rst_n)
                mod_q[w*DATA_W +: DATA_W] <= '0;
            else if (wr_ok && mod_sel[w])
                mod_q[w*DATA_W +: DATA_W] <= wdata;
        end
    end

    for (genvar w = 0; w < LVL_WORDS; w++) begin : g_lvl
        assign lvl_sel[w] = lvl_hit && (lvl_off[ADDR_W-1:2] == IDX_W'(w));
        // Access-level word storage
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[w*DATA_W +: DATA_W] <= '0;
            else if (wr_ok && lvl_sel[w])
                lvl_q[w*DATA_W +: DATA_W] <= wdata;
        end
    end

    // Read mux, gated by the access rule
    always_comb begin
        rdata = '0;
        for (int w = 0; w < MOD_WORDS; w++)
            if (mod_sel[w]) rdata = rdata | mod_q[w*DATA_W +: DATA_W];
        for (int w = 0; w < LVL_WORDS; w++)
            if (lvl_sel[w]) rdata = rdata | lvl_q[w*DATA_W +: DATA_W];
        if (!acc_ok) rdata = '0;
    end

    assign mod_bits = mod_q[NUM_IRQ-1:0];
    assign lvl_bits = lvl_q[2*NUM_IRQ-1:0];

endmodule

// File: rtl/grp_resolver.sv
`timescale 1ns/1ps
// Per-interrupt group decode and group-enable lookup. Purely
// combinational; assumes enables and flags come from registers.
module grp_resolver
    import irq_grp_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic                 ds,
    input  logic                 en_g0,
    input  logic                 en_g1ns,
    input  logic                 en_g1s,
    input  logic [NUM_IRQ-1:0]   grp_bit,
    input  logic [NUM_IRQ-1:0]   mod_bit,
    output logic [2*NUM_IRQ-1:0] grp_sel,
    output logic [NUM_IRQ-1:0]   grp_en
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        grp_e g;
        // Decode one interrupt and pick its group's enable
        always_comb begin
            g = grp_decode(ds, grp_bit[i], mod_bit[i]);
            unique case (g)
                GRP_1NS: grp_en[i] = en_g1ns;
                GRP_1S:  grp_en[i] = en_g1s;
                default: grp_en[i] = en_g0;
            endcase
        end
        assign grp_sel[2*i +: 2] = g;
    end

endmodule

// File: rtl/irq_grp_ctrl.sv
`timescale 1ns/1ps
// Top: banked group control word, secure-only modifier and access-level
// arrays, and per-interrupt group resolution. Reads are registered
// (one cycle latency); unmapped offsets read 0 and ignore writes.
module irq_grp_ctrl
    import irq_grp_pkg::*;
#(
    parameter int NUM_IRQ      = 64,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 12,
    parameter bit HAS_SECURITY = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_vld,
    input  logic                 req_wr,
    input  logic                 req_sec,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic [DATA_W-1:0]    rd_data,
    input  logic [NUM_IRQ-1:0]   irq_grp_bit,
    output logic [2*NUM_IRQ-1:0] irq_grp_sel,
    output logic [NUM_IRQ-1:0]   irq_grp_en,
    output logic [2*NUM_IRQ-1:0] irq_ns_lvl
);

    logic              ds_q, en_g0, en_g1ns, en_g1s;
    logic              ctrl_hit, acc_ok;
    logic [DATA_W-1:0] ctrl_rdata, bank_rdata;
    logic [NUM_IRQ-1:0] mod_bits;

    assign ctrl_hit = (req_addr[ADDR_W-1:2] == '0);
    assign acc_ok   = !ds_q && req_sec;

    grp_ctrl_reg #(.DATA_W(DATA_W), .HAS_SECURITY(HAS_SECURITY)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (req_vld && req_wr && ctrl_hit),
        .sec     (req_sec),
        .wdata   (req_wdata),
        .ds      (ds_q),
        .en_g0   (en_g0),
        .en_g1ns (en_g1ns),
        .en_g1s  (en_g1s),
        .rdata   (ctrl_rdata)
    );

    grp_mod_bank #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_wr   (req_wr),
        .acc_ok   (acc_ok),
        .req_addr (req_addr),
        .wdata    (req_wdata),
        .mod_bits (mod_bits),
        .lvl_bits (irq_ns_lvl),
        .rdata    (bank_rdata)
    );

    grp_resolver #(.NUM_IRQ(NUM_IRQ)) res_i (
        .ds      (ds_q),
        .en_g0   (en_g0),
        .en_g1ns (en_g1ns),
        .en_g1s  (en_g1s),
        .grp_bit (irq_grp_bit),
        .mod_bit (mod_bits),
        .grp_sel (irq_grp_sel),
        .grp_en  (irq_grp_en)
    );

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (req_vld && !req_wr)
            rd_data <= ctrl_hit ? ctrl_rdata : bank_rdata;
    end

endmodule

// File: rtl/irq_grp_ctrl_chk.sv
`timescale 1ns/1ps
// Checker: temporal properties of the banked control state and the
// secure-only arrays. Bound into irq_grp_ctrl below.
module irq_grp_ctrl_chk #(
    parameter int NUM_IRQ = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_vld,
    input logic                 req_wr,
    input logic                 req_sec,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [DATA_W-1:0]    req_wdata,
    input logic                 ds,
    input logic                 en_g0,
    input logic                 en_g1s,
    input logic [NUM_IRQ-1:0]   mod_bits,
    input logic [2*NUM_IRQ-1:0] lvl_bits,
    input logic [2*NUM_IRQ-1:0] grp_sel
);

    logic ctl_wr;
    assign ctl_wr = req_vld && req_wr && (req_addr == '0);

    // R5: disable-security flag is sticky
    p_ds_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ds |=> ds);

    // R4: writing the flag clears secure group 1 enable
    p_g1s_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && req_sec && !ds && req_wdata[6]) |=> (!en_g1s && ds));

    // R3: non-secure control write leaves the secure fields alone
    p_ns_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !req_sec && !ds) |=> ($stable(en_g0) && $stable(en_g1s) && $stable(ds)));

    // R7: arrays change only under secure access with security enabled
    p_bank_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr && (ds || !req_sec)) |=> ($stable(mod_bits) && $stable(lvl_bits)));

    // R6: no secure group 1 decode while security is disabled
    p_no_g1s_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ds |-> (grp_sel[1:0] != 2'b10 && grp_sel[2*NUM_IRQ-1 -: 2] != 2'b10));

endmodule

bind irq_grp_ctrl irq_grp_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_wr    (req_wr),
    .req_sec   (req_sec),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ds        (ds_q),
    .en_g0     (en_g0),
    .en_g1s    (en_g1s),
    .mod_bits  (mod_bits),
    .lvl_bits  (irq_ns_lvl),
    .grp_sel   (irq_grp_sel)
);

// File: tb/irq_grp_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_grp_ctrl_tb_top;

    localparam int N  = 64;
    localparam int DW = 32;
    localparam int AW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0, req_wr = 1'b0, req_sec = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [DW-1:0]   rd_data;
    logic [N-1:0]    irq_grp_bit = '0;
    logic [2*N-1:0]  irq_grp_sel;
    logic [N-1:0]    irq_grp_en;
    logic [2*N-1:0]  irq_ns_lvl;

    int total = 0;
    int bad   = 0;

    // Model state
    logic m_ds, m_g0, m_g1ns, m_g1s;
    logic [N-1:0]   m_mod;
    logic [2*N-1:0] m_lvl;

    always #2.5 clk = ~clk;

    irq_grp_ctrl #(.NUM_IRQ(N), .DATA_W(DW), .ADDR_W(AW), .HAS_SECURITY(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_sec(req_sec), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .irq_grp_bit(irq_grp_bit), .irq_grp_sel(irq_grp_sel),
        .irq_grp_en(irq_grp_en), .irq_ns_lvl(irq_ns_lvl)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ctrl_exp(input logic sec);
        logic [DW-1:0] v = '0;
        if (m_ds)     v = 32'h50 | {30'd0, m_g1ns, m_g0};
        else if (sec) v = 32'h30 | {29'd0, m_g1s, m_g1ns, m_g0};
        else          v = 32'h10 | {30'd0, m_g1ns, 1'b0};
        return v;
    endfunction

    function automatic logic [DW-1:0] bank_exp(input logic [AW-1:0] a, input logic sec);
        if (m_ds || !sec) return '0;
        if (a >= 12'hD00 && a < 12'hD08) return m_mod[(a[3:2])*32 +: 32];
        if (a >= 12'hE00 && a < 12'hE10) return m_lvl[(a[3:2])*32 +: 32];
        return '0;
    endfunction

    task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sec);
        if (a[AW-1:2] == '0) begin
            if (m_ds) begin m_g0 = d[0]; m_g1ns = d[1]; end
            else if (sec) begin
                m_ds = d[6]; m_g0 = d[0]; m_g1ns = d[1]; m_g1s = d[6] ? 1'b0 : d[2];
            end else m_g1ns = d[1];
        end else if (!m_ds && sec) begin
            if (a >= 12'hD00 && a < 12'hD08) m_mod[(a[3:2])*32 +: 32] = d;
            if (a >= 12'hE00 && a < 12'hE10) m_lvl[(a[3:2])*32 +: 32] = d;
        end
    endtask

    // Check decode, enable and level outputs against the model (R6, R7, R8)
    task automatic chk_outputs();
        logic [2*N-1:0] es;
        logic [N-1:0]   ee;
        for (int i = 0; i < N; i++) begin
            logic [1:0] g;
            if (irq_grp_bit[i])          g = 2'b01;
            else if (!m_ds && m_mod[i])  g = 2'b10;
            else                         g = 2'b00;
            es[2*i +: 2] = g;
            ee[i] = (g == 2'b01) ? m_g1ns : (g == 2'b10) ? m_g1s : m_g0;
        end
        chk("R6 group decode", 128'(irq_grp_sel), 128'(es));
        chk("R8 group enable", 128'(irq_grp_en), 128'(ee));
        chk("R7 level output", 128'(irq_ns_lvl), 128'(m_lvl));
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sec);
        req_vld = 1'b1; req_wr = 1'b1; req_sec = sec; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
        model_wr(a, d, sec);
    endtask

    task automatic do_rd(input string req, input logic [AW-1:0] a, input logic sec);
        logic [DW-1:0] e;
        e = (a[AW-1:2] == '0) ? ctrl_exp(sec) : bank_exp(a, sec);
        req_vld = 1'b1; req_wr = 1'b0; req_sec = sec; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_vld = 1'b0;
        chk(req, 128'(rd_data), 128'(e));
    endtask

    function automatic logic [AW-1:0] pick_addr();
        case ($urandom_range(0, 3))
            0: return 12'h000;
            1: return 12'hD00 + AW'($urandom_range(0, 2) * 4);
            2: return 12'hE00 + AW'($urandom_range(0, 4) * 4);
            default: return AW'($urandom_range(1, 40) * 4);
        endcase
    endfunction

    task automatic rand_phase(input int n, input bit mask_ds);
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] a = pick_addr();
            logic s = 1'($urandom_range(0, 1));
            logic [DW-1:0] d = $urandom();
            irq_grp_bit = {$urandom(), $urandom()};
            if (mask_ds && a == 12'h000) d[6] = 1'b0;
            if ($urandom_range(0, 1) == 1) do_wr(a, d, s);
            else do_rd("R2 R3 R5 R7 R9 random read", a, s);
            chk_outputs();
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ds = 1'b0; m_g0 = 1'b0; m_g1ns = 1'b0; m_g1s = 1'b0;
        m_mod = '0; m_lvl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        do_rd("R1 R2 reset secure ctrl", 12'h000, 1'b1);
        do_rd("R1 R3 reset nonsecure ctrl", 12'h000, 1'b0);
        do_rd("R1 reset modifier", 12'hD04, 1'b1);
        do_rd("R1 reset level", 12'hE0C, 1'b1);
        chk_outputs();
        // R2/R4: secure write, full view
        do_wr(12'h000, 32'h0000_0007, 1'b1);
        do_rd("R2 R4 secure ctrl after set", 12'h000, 1'b1);
        chk("R2 literal", 128'(rd_data), 128'h37);
        // R3: non-secure view and write
        do_rd("R3 nonsecure ctrl", 12'h000, 1'b0);
        chk("R3 literal", 128'(rd_data), 128'h12);
        do_wr(12'h000, 32'hFFFF_FFFD, 1'b0);
        do_rd("R3 nonsecure write only g1ns", 12'h000, 1'b1);
        chk("R3 literal after", 128'(rd_data), 128'h35);
        // R7: non-secure array write ignored; secure write lands
        do_wr(12'hD00, 32'hFFFF_FFFF, 1'b0);
        do_rd("R7 nonsecure modifier ignored", 12'hD00, 1'b1);
        do_wr(12'hD04, 32'h8000_0001, 1'b1);
        do_wr(12'hE04, 32'hC000_0003, 1'b1);
        irq_grp_bit = '0;
        #0 chk_outputs();
        do_rd("R7 nonsecure level reads zero", 12'hE04, 1'b0);
        // R9: unmapped offset
        do_wr(12'h100, 32'hFFFF_FFFF, 1'b1);
        do_rd("R9 unmapped reads zero", 12'h100, 1'b1);
        rand_phase(400, 1'b1);
        // R4/R5: disable security, g1s forced low
        do_wr(12'h000, 32'h0000_0047, 1'b1);
        do_rd("R4 R5 ds view", 12'h000, 1'b1);
        chk("R4 literal", 128'(rd_data), 128'h53);
        do_wr(12'h000, 32'h0000_0000, 1'b1);
        do_rd("R5 flag sticky", 12'h000, 1'b0);
        chk("R5 literal", 128'(rd_data), 128'h50);
        do_rd("R7 locked under ds", 12'hD04, 1'b1);
        rand_phase(400, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule